// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits in the transmit path of a DS3 framer, after the overhead bits have been generated. It corrupts chosen overhead bits on purpose so that far-end equipment and monitoring logic can be tested. The stream arrives one bit per clock. Alongside each bit comes a slot code that says what kind of bit it is, plus pulses that mark the first bit of each frame and of each subframe. The block returns the stream one clock later with the selected errors applied.

Four error types are supported: framing, path parity, C-bit parity and far-end block error. Each type has its own enable and its own single or continuous select. In continuous mode a type corrupts every opportunity it sees. In single mode it waits for a request. Requests come either from a synchronous register strobe or from an asynchronous test pin, and a select input chooses which. Every enabled single-mode type records each request in its own small counter and uses up one count per error it inserts. A per-type flag shows whether requests are still waiting.

Top module: `ds3_err_injector`

## Requirements
- R1: `dataOut` equals `dataIn` delayed by one clock, except on the bits an active error targets. Slot codes are 0 payload, 1 subframe alignment (F), 2 multiframe alignment (M), 3 path parity (P), 4 C-bit parity group, 5 far-end block error group, and 6 or 7 other overhead. Bits with codes 0, 6 and 7 are never changed. While `rstN` is low, `dataOut` and `pendFlag` are 0.
- R2: `typeEn`, `contMode` and `pendFlag` use bit 0 for framing, bit 1 for path parity, bit 2 for C-bit parity and bit 3 for far-end block error. With `framingMode` = 0, a framing error inverts the next F slot.
- R3: With `framingMode` = 1, a framing error inverts the next M slot.
- R4: With `framingMode` = 2, a framing error starts at the next subframe start and inverts every F slot of that one subframe.
- R5: With `framingMode` = 3, a framing error starts at the next frame start and inverts the first M slot of that frame and the first M slot of the following frame.
- R6: A path parity error inverts every P slot of the frame that begins at the next frame start.
- R7: A C-bit parity error inverts every code-4 slot of the frame that begins at the next frame start.
- R8: A far-end block error forces every code-5 slot to 0 for the whole frame that begins at the next frame start. It never drives such a bit to 1.
- R9: A type in continuous mode corrupts every one of its opportunities, with no request needed. It ignores requests, and its `pendFlag` bit stays 0.
- R10: A disabled type never corrupts a bit and never records a request. One request is recorded by every type that is enabled and in single mode.
- R11: With `reqFromPin` = 0, only `reqStrobe` (one request per high cycle) counts. With `reqFromPin` = 1, only a rising edge of `reqPin` counts. That edge passes a two-flop synchronizer, so `pendFlag` rises at the third rising clock edge after the pin goes high. A pin held high counts once.
- R12: Each type counts up to 3 waiting requests; further requests are lost while the count is full. Each insertion uses one count. A request that arrives in the same cycle as an insertion start is still counted. A request that arrives while a multi-bit error is in progress is applied after that error ends. `pendFlag[i]` is high while the count of type i is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Serial stream bit |
| slotCode | input | 3 | Kind of the current bit (see R1) |
| frameStart | input | 1 | High on the first bit of a frame |
| subframeStart | input | 1 | High on the first bit of a subframe |
| typeEn | input | 4 | Per-type enables |
| contMode | input | 4 | Per-type continuous (1) or single (0) mode |
| framingMode | input | 2 | Framing error variant (see R2 to R5) |
| reqFromPin | input | 1 | Request source select: 1 pin, 0 strobe |
| reqStrobe | input | 1 | Synchronous register request strobe |
| reqPin | input | 1 | Asynchronous external request input |
| dataOut | output | 1 | Stream with errors applied, one clock late |
| pendFlag | output | 4 | Per-type waiting-request indication |

## Verification
The sharpest overlap is a new request that is accepted in the same cycle as an insertion that uses up the previous one. When that happens, the counter must increment and decrement at once and keep the new request. The bench provokes this twice. Once, it places the second strobe exactly on the subframe start that launches a pending subframe-wide framing error. Once, it places the second strobe on the F slot that takes a pending single-bit error. It judges each case by counting the inverted F bits over the frame and in each subframe. The result must be two complete errors, with no extra and no missing one.

// File: rtl/errinj_pkg.sv
package errinj_pkg;

  typedef enum logic [2:0] {
    SLOT_DATA = 3'd0,
    SLOT_F    = 3'd1,
    SLOT_M    = 3'd2,
    SLOT_P    = 3'd3,
    SLOT_CP   = 3'd4,
    SLOT_FEBE = 3'd5,
    SLOT_XO   = 3'd6,
    SLOT_XO2  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    FM_FBIT = 2'd0,
    FM_MBIT = 2'd1,
    FM_SEF  = 2'd2,
    FM_OOMF = 2'd3
  } fmode_e;

  localparam int NTYPE   = 4;
  localparam int TY_FRM  = 0;
  localparam int TY_PAR  = 1;
  localparam int TY_CPAR = 2;
  localparam int TY_FEBE = 3;

  // strobes from control to datapath, valid for the current bit
  typedef struct packed {
    logic flipF;
    logic flipM;
    logic flipP;
    logic flipC;
    logic zeroC4;
  } strobe_t;

endpackage

// File: rtl/errinj_reqsrc.sv
module errinj_reqsrc #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinSel,
  input  logic strobe,
  input  logic pinAsync,
  output logic reqPulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
      lastQ <= syncQ[SYNC_STAGES-1];
    end
  end

  // only a rising edge of the synchronized pin is a request
  assign reqPulse = pinSel ? (syncQ[SYNC_STAGES-1] & ~lastQ) : strobe;

endmodule

// File: rtl/errinj_ctrl.sv
module errinj_ctrl
  import errinj_pkg::*;
#(
  parameter int PEND_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  slot_e            slot,
  input  logic             frameStart,
  input  logic             subframeStart,
  input  logic [NTYPE-1:0] typeEn,
  input  logic [NTYPE-1:0] contMode,
  input  fmode_e           fmode,
  input  logic             reqPulse,
  output strobe_t          stb,
  output logic [NTYPE-1:0] pendFlag
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [NTYPE-1:0] hasPend;
  logic [NTYPE-1:0] takeW;
  logic [NTYPE-1:0] hitW;

  // per-type waiting-request counters
  for (genvar i = 0; i < NTYPE; i++) begin : g_pend
    logic [PEND_W-1:0] cnt;
    logic accept;
    assign accept     = reqPulse & typeEn[i] & ~contMode[i];
    assign hasPend[i] = (cnt != '0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (accept && !takeW[i]) begin
        if (cnt != PEND_MAX) cnt <= cnt + 1'b1;
      end else if (takeW[i] && !accept) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // frame-wide window engines for the parity and block-error types
  for (genvar i = TY_PAR; i < NTYPE; i++) begin : g_win
    localparam slot_e TGT = (i == TY_PAR) ? SLOT_P : (i == TY_CPAR) ? SLOT_CP : SLOT_FEBE;
    logic actQ;
    logic actNow;
    assign actNow  = frameStart ? (typeEn[i] & (contMode[i] | hasPend[i])) : actQ;
    assign takeW[i] = frameStart & typeEn[i] & ~contMode[i] & hasPend[i];
    assign hitW[i]  = actNow & typeEn[i] & (slot == TGT);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) actQ <= 1'b0;
      else       actQ <= actNow;
    end
  end

  // framing engine
  logic       frmArm, takeFrm, hitF, hitM;
  logic       sefAct, sefNow;
  logic [1:0] oomfLeft, oomfLeftNow;
  logic       oomfHit, oomfHitNow;

  assign frmArm = typeEn[TY_FRM] & (contMode[TY_FRM] | hasPend[TY_FRM]);

  always_comb begin
    hitF        = 1'b0;
    hitM        = 1'b0;
    takeFrm     = 1'b0;
    sefNow      = sefAct;
    oomfLeftNow = oomfLeft;
    oomfHitNow  = oomfHit & ~frameStart;
    unique case (fmode)
      FM_FBIT: begin
        hitF    = frmArm && (slot == SLOT_F);
        takeFrm = hitF && !contMode[TY_FRM];
      end
      FM_MBIT: begin
        hitM    = frmArm && (slot == SLOT_M);
        takeFrm = hitM && !contMode[TY_FRM];
      end
      FM_SEF: begin
        if (subframeStart) begin
          sefNow  = frmArm;
          takeFrm = frmArm && !contMode[TY_FRM];
        end
        hitF = sefNow && typeEn[TY_FRM] && (slot == SLOT_F);
      end
      FM_OOMF: begin
        if (frameStart && (oomfLeft == 2'd0) && frmArm) begin
          oomfLeftNow = contMode[TY_FRM] ? 2'd1 : 2'd2;
          takeFrm     = !contMode[TY_FRM];
        end
        hitM = typeEn[TY_FRM] && (slot == SLOT_M) && (oomfLeftNow != 2'd0) && !oomfHitNow;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sefAct   <= 1'b0;
      oomfLeft <= 2'd0;
      oomfHit  <= 1'b0;
    end else begin
      sefAct   <= (fmode == FM_SEF) && sefNow;
      oomfLeft <= (fmode != FM_OOMF) ? 2'd0 : (hitM ? oomfLeftNow - 2'd1 : oomfLeftNow);
      oomfHit  <= (fmode == FM_OOMF) && (hitM || oomfHitNow);
    end
  end

  assign takeW[TY_FRM] = takeFrm;
  assign hitW[TY_FRM]  = hitF | hitM;

  assign stb.flipF  = hitF;
  assign stb.flipM  = hitM;
  assign stb.flipP  = hitW[TY_PAR];
  assign stb.flipC  = hitW[TY_CPAR];
  assign stb.zeroC4 = hitW[TY_FEBE];
  assign pendFlag   = hasPend;

endmodule

// File: rtl/errinj_datapath.sv
module errinj_datapath
  import errinj_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dataIn,
  input  strobe_t stb,
  output logic    dataOut
);
  logic flipAny;
  assign flipAny = stb.flipF | stb.flipM | stb.flipP | stb.flipC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= 1'b0;
    else       dataOut <= (dataIn ^ flipAny) & ~stb.zeroC4;
  end
endmodule

// File: rtl/ds3_err_injector.sv
module ds3_err_injector
  import errinj_pkg::*;
#(
  parameter int PEND_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataIn,
  input  logic [2:0] slotCode,
  input  logic       frameStart,
  input  logic       subframeStart,
  input  logic [3:0] typeEn,
  input  logic [3:0] contMode,
  input  logic [1:0] framingMode,
  input  logic       reqFromPin,
  input  logic       reqStrobe,
  input  logic       reqPin,
  output logic       dataOut,
  output logic [3:0] pendFlag
);
  logic    reqPulse;
  strobe_t stb;

  errinj_reqsrc #(.SYNC_STAGES(SYNC_STAGES)) reqI (
    .clk(clk), .rstN(rstN), .pinSel(reqFromPin), .strobe(reqStrobe),
    .pinAsync(reqPin), .reqPulse(reqPulse)
  );

  errinj_ctrl #(.PEND_W(PEND_W)) ctrlI (
    .clk(clk), .rstN(rstN), .slot(slot_e'(slotCode)), .frameStart(frameStart),
    .subframeStart(subframeStart), .typeEn(typeEn), .contMode(contMode),
    .fmode(fmode_e'(framingMode)), .reqPulse(reqPulse), .stb(stb), .pendFlag(pendFlag)
  );

  errinj_datapath dpI (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .stb(stb), .dataOut(dataOut)
  );
endmodule

// File: rtl/ds3_err_injector_chk.sv
module ds3_err_injector_chk
  import errinj_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       dataIn,
  input logic [2:0] slotCode,
  input logic [3:0] typeEn,
  input logic [3:0] contMode,
  input logic       dataOut,
  input logic [3:0] pendFlag
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  payload_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && ($past(slotCode) == SLOT_DATA || $past(slotCode) == SLOT_XO ||
              $past(slotCode) == SLOT_XO2) |-> dataOut == $past(dataIn));

  // R10
  disabled_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && ($past(typeEn) == 4'b0000) |-> dataOut == $past(dataIn));

  // R8
  febe_force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && ($past(slotCode) == SLOT_FEBE) && (dataOut != $past(dataIn)) |-> !dataOut);

  // R6
  parity_flip_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && ($past(slotCode) == SLOT_P) && (dataOut != $past(dataIn)) |-> $past(typeEn[TY_PAR]));

  // R9
  pend_rise_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pendFlag & ~$past(pendFlag) & (~$past(typeEn) | $past(contMode))) == 4'b0000));
endmodule

bind ds3_err_injector ds3_err_injector_chk chkI (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .slotCode(slotCode), .typeEn(typeEn),
  .contMode(contMode), .dataOut(dataOut), .pendFlag(pendFlag)
);

// File: tb/ds3_err_injector_test.sv
`timescale 1ns/1ps
module ds3_err_injector_test;
  localparam int SUB_LEN = 12;
  localparam int NSUB    = 5;
  localparam int FR_LEN  = SUB_LEN * NSUB;
  localparam int NFR     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic [2:0] slotCode = 3'd0;
  logic frameStart = 1'b0, subframeStart = 1'b0;
  logic [3:0] typeEn = 4'd0, contMode = 4'd0;
  logic [1:0] framingMode = 2'd0;
  logic reqFromPin = 1'b0, reqStrobe = 1'b0, reqPin = 1'b0;
  logic dataOut;
  logic [3:0] pendFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ds3_err_injector uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .slotCode(slotCode),
    .frameStart(frameStart), .subframeStart(subframeStart), .typeEn(typeEn),
    .contMode(contMode), .framingMode(framingMode), .reqFromPin(reqFromPin),
    .reqStrobe(reqStrobe), .reqPin(reqPin), .dataOut(dataOut), .pendFlag(pendFlag)
  );

  typedef struct packed {
    logic [3:0]      en;
    logic [3:0]      cont;
    logic [1:0]      fm;
    logic            pinSel;
    logic            drivePin;
    logic [5:0]      req2;
    logic [0:3][4:0] eF;
    logic [0:3][1:0] eM;
    logic [0:3][1:0] eP;
    logic [0:3][1:0] eC;
    logic [0:3][1:0] eZ;
    logic [2:0]      fMax;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'b0000,4'b0000,2'd0,1'b0,1'b0,6'd0,  20'd0,                       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0001,4'b0000,2'd0,1'b0,1'b0,6'd0,  {5'd1,5'd0,5'd0,5'd0},       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd1},
    '{4'b0001,4'b0000,2'd1,1'b0,1'b0,6'd0,  20'd0,                       {2'd1,2'd0,2'd0,2'd0}, 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0001,4'b0000,2'd2,1'b0,1'b0,6'd0,  {5'd4,5'd0,5'd0,5'd0},       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd4},
    '{4'b0001,4'b0000,2'd3,1'b0,1'b0,6'd0,  20'd0,                       {2'd0,2'd1,2'd1,2'd0}, 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0010,4'b0000,2'd0,1'b0,1'b0,6'd0,  20'd0,                       8'h00,                 {2'd0,2'd2,2'd0,2'd0}, 8'h00,                 8'h00,                 3'd0},
    '{4'b0100,4'b0000,2'd0,1'b0,1'b0,6'd0,  20'd0,                       8'h00,                 8'h00,                 {2'd0,2'd3,2'd0,2'd0}, 8'h00,                 3'd0},
    '{4'b1000,4'b0000,2'd0,1'b0,1'b0,6'd0,  20'd0,                       8'h00,                 8'h00,                 8'h00,                 {2'd0,2'd3,2'd0,2'd0}, 3'd0},
    '{4'b1111,4'b1111,2'd0,1'b0,1'b0,6'd0,  {5'd20,5'd20,5'd20,5'd20},   8'h00,                 {2'd2,2'd2,2'd2,2'd2}, {2'd3,2'd3,2'd3,2'd3}, {2'd3,2'd3,2'd3,2'd3}, 3'd4},
    '{4'b0001,4'b0001,2'd3,1'b0,1'b0,6'd0,  20'd0,                       {2'd1,2'd1,2'd1,2'd1}, 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0001,4'b0001,2'd1,1'b0,1'b0,6'd0,  20'd0,                       {2'd2,2'd2,2'd2,2'd2}, 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0010,4'b0000,2'd0,1'b1,1'b1,6'd0,  20'd0,                       8'h00,                 {2'd0,2'd2,2'd0,2'd0}, 8'h00,                 8'h00,                 3'd0},
    '{4'b1111,4'b0000,2'd0,1'b1,1'b0,6'd0,  20'd0,                       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b1111,4'b0000,2'd0,1'b0,1'b1,6'd0,  20'd0,                       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0010,4'b0000,2'd0,1'b0,1'b0,6'd3,  20'd0,                       8'h00,                 {2'd0,2'd2,2'd2,2'd0}, 8'h00,                 8'h00,                 3'd0},
    '{4'b0001,4'b0000,2'd2,1'b0,1'b0,6'd12, {5'd8,5'd0,5'd0,5'd0},       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd4},
    '{4'b0001,4'b0000,2'd3,1'b0,1'b0,6'd3,  20'd0,                       {2'd0,2'd1,2'd1,2'd1}, 8'h00,                 8'h00,                 8'h00,                 3'd0},
    '{4'b0011,4'b0000,2'd0,1'b0,1'b0,6'd0,  {5'd1,5'd0,5'd0,5'd0},       8'h00,                 {2'd0,2'd2,2'd0,2'd0}, 8'h00,                 8'h00,                 3'd1},
    '{4'b0001,4'b0000,2'd0,1'b0,1'b0,6'd3,  {5'd2,5'd0,5'd0,5'd0},       8'h00,                 8'h00,                 8'h00,                 8'h00,                 3'd2}
  };

  function automatic string tagOf(input int v);
    case (v)
      0, 17:       return "R10";
      1:           return "R2";
      2:           return "R3";
      3:           return "R4";
      4:           return "R5";
      5:           return "R6";
      6:           return "R7";
      7:           return "R8";
      8, 9, 10:    return "R9";
      11, 12, 13:  return "R11";
      default:     return "R12";
    endcase
  endfunction

  function automatic logic [2:0] slotOf(input int pos);
    int sub = pos / SUB_LEN;
    int idx = pos % SUB_LEN;
    if (idx == 1 || idx == 3 || idx == 6 || idx == 9) return 3'd1;
    if (idx == 0) begin
      if (sub == 0)            return 3'd6;
      if (sub == 1 || sub == 2) return 3'd3;
      return 3'd2;
    end
    if (idx == 2 || idx == 5 || idx == 8) begin
      if (sub == 2) return 3'd4;
      if (sub == 3) return 3'd5;
      return 3'd6;
    end
    return 3'd0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    dataIn = 1'b0; slotCode = 3'd0; frameStart = 1'b0; subframeStart = 1'b0;
    reqStrobe = 1'b0; reqPin = 1'b0;
  endtask

  task automatic doReset(input logic [3:0] en, input logic [3:0] cont, input logic [1:0] fm,
                         input logic pinSel);
    @(negedge clk);
    rstN = 1'b0;
    idleInputs();
    typeEn = en; contMode = cont; framingMode = fm; reqFromPin = pinSel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runVec(input int v);
    vec_t t;
    int cF[NFR], cM[NFR], cP[NFR], cC[NFR], cZ[NFR];
    int subF[NFR][NSUB];
    int other, fMax, pf, ps;
    logic prevValid, prevData, flip;
    logic [2:0] prevSlot;
    t = VEC[v];
    other = 0; fMax = 0; pf = 0; ps = 0;
    prevValid = 1'b0; prevData = 1'b0; prevSlot = 3'd0;
    for (int f = 0; f < NFR; f++) begin
      cF[f] = 0; cM[f] = 0; cP[f] = 0; cC[f] = 0; cZ[f] = 0;
      for (int s = 0; s < NSUB; s++) subF[f][s] = 0;
    end
    doReset(t.en, t.cont, t.fm, t.pinSel);
    for (int n = 0; n <= NFR * FR_LEN; n++) begin
      if (n > 0) @(negedge clk);
      if (prevValid) begin
        flip = dataOut ^ prevData;
        case (prevSlot)
          3'd1: if (flip) begin cF[pf]++; subF[pf][ps]++; end
          3'd2: if (flip) cM[pf]++;
          3'd3: if (flip) cP[pf]++;
          3'd4: if (flip) cC[pf]++;
          3'd5: if (!dataOut) cZ[pf]++;
          default: if (flip) other++;
        endcase
      end
      if (n < NFR * FR_LEN) begin
        int f   = n / FR_LEN;
        int pos = n % FR_LEN;
        slotCode      = slotOf(pos);
        frameStart    = (pos == 0);
        subframeStart = (pos % SUB_LEN == 0);
        dataIn        = (slotCode == 3'd5) ? 1'b1 : 1'((pos % 2) ^ ((pos / 8) % 2) ^ (f % 2));
        reqStrobe     = !t.drivePin && (f == 0) && (pos == 2 || (t.req2 != 0 && pos == int'(t.req2)));
        reqPin        = t.drivePin && (n >= 2);
        prevValid = 1'b1; prevData = dataIn; prevSlot = slotCode;
        pf = f; ps = pos / SUB_LEN;
      end else begin
        idleInputs();
      end
    end
    for (int f = 0; f < NFR; f++) begin
      check(tagOf(v), $sformatf("vec%0d frame%0d F flips", v, f), cF[f], int'(t.eF[f]));
      check(tagOf(v), $sformatf("vec%0d frame%0d M flips", v, f), cM[f], int'(t.eM[f]));
      check(tagOf(v), $sformatf("vec%0d frame%0d P flips", v, f), cP[f], int'(t.eP[f]));
      check(tagOf(v), $sformatf("vec%0d frame%0d C3 flips", v, f), cC[f], int'(t.eC[f]));
      check(tagOf(v), $sformatf("vec%0d frame%0d C4 zeroed", v, f), cZ[f], int'(t.eZ[f]));
      for (int s = 0; s < NSUB; s++) if (subF[f][s] > fMax) fMax = subF[f][s];
    end
    check(tagOf(v), $sformatf("vec%0d max F flips in one subframe", v), fMax, int'(t.fMax));
    check("R1", $sformatf("vec%0d payload/other flips", v), other, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    idleInputs();
    dataIn = 1'b1; slotCode = 3'd1; typeEn = 4'b1111; contMode = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1", "dataOut in reset", int'(dataOut), 0);
    check("R1", "pendFlag in reset", int'(pendFlag), 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) runVec(v);

    // R12: counting and saturation at 3
    doReset(4'b0010, 4'b0000, 2'd0, 1'b0);
    @(negedge clk); reqStrobe = 1'b1;
    @(negedge clk); reqStrobe = 1'b0;
    check("R12", "pendFlag after one request", int'(pendFlag), 2);
    reqStrobe = 1'b1;
    repeat (4) @(negedge clk);
    reqStrobe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      frameStart = 1'b1;
      @(negedge clk); frameStart = 1'b0;
      check("R12", $sformatf("pendFlag after %0d frame starts", k + 1), int'(pendFlag), (k < 2) ? 2 : 0);
      @(negedge clk);
    end

    // R9: continuous mode never records
    doReset(4'b0010, 4'b0010, 2'd0, 1'b0);
    @(negedge clk); reqStrobe = 1'b1;
    @(negedge clk); reqStrobe = 1'b0;
    check("R9", "pendFlag with continuous type", int'(pendFlag), 0);

    // R10: disabled type never records
    doReset(4'b0000, 4'b0000, 2'd0, 1'b0);
    @(negedge clk); reqStrobe = 1'b1;
    @(negedge clk); reqStrobe = 1'b0;
    check("R10", "pendFlag with all disabled", int'(pendFlag), 0);

    // R11: synchronizer latency of the pin path
    doReset(4'b0100, 4'b0000, 2'd0, 1'b1);
    @(negedge clk); reqPin = 1'b1;
    @(negedge clk);
    check("R11", "pendFlag one edge after pin", int'(pendFlag), 0);
    @(negedge clk);
    check("R11", "pendFlag two edges after pin", int'(pendFlag), 0);
    @(negedge clk);
    check("R11", "pendFlag three edges after pin", int'(pendFlag), 4);
    repeat (4) @(negedge clk);
    reqPin = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule